// File: doc/BRIEF.md
# Register-Bank Command Execution Unit

The unit executes one command per request against an internal bank of sixteen 32-bit registers. A request gives a 4-bit opcode, two 4-bit source register indices, a 4-bit destination index, a 2-bit tag and a 32-bit data word. The arithmetic and shift commands take their operands from the bank rather than from the request. Store moves the request data word into the bank. Fetch returns the contents of a register on the output bus.

The opcode input doubles as the request strobe. Any defined opcode present at a rising clock edge is executed in that edge. Its response code, echoed tag and output data are registered and appear in the following cycle. A register written by one request is visible to a request presented in the next cycle. Opcodes that are not defined, including 0000, are dropped without effect.

Top module: `rbx_exec_top`

## Requirements
- R1: After reset, every bank register reads as zero, and resp_o, tag_o and data_o are all zero.
- R2: Opcode 0001 writes the unsigned sum of register d1 and register d2 into register r1 and responds with code 01.
- R3: If an add produces a carry out of bit 31, the response code is 10 and register r1 keeps its previous value.
- R4: Opcode 0010 writes register d1 minus register d2 into r1 with code 01 when d1 >= d2. When d1 < d2 (unsigned) it responds 10 and leaves r1 unchanged.
- R5: Opcode 0101 writes register d1 shifted left logically by bits [4:0] of register d2 into r1, with code 01. The other bits of d2 are ignored.
- R6: Opcode 0110 writes register d1 shifted right logically (zero fill) by bits [4:0] of register d2 into r1, with code 01.
- R7: Opcode 1001 writes data_i into register r1 and responds with code 01.
- R8: Opcode 1010 responds with code 01 and presents register d1 on data_o. For every other command, data_o is zero.
- R9: Any opcode other than 0001, 0010, 0101, 0110, 1001 and 1010 writes no register. In the next cycle resp_o is 00 (no response) and tag_o and data_o are zero.
- R10: The response to a request appears in the cycle after the request with tag_o equal to its tag_i. A register written by a request is read with its new value by a request in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 4 | Opcode; undefined values mean no request |
| d1_i | input | 4 | First source register index |
| d2_i | input | 4 | Second source register index |
| r1_i | input | 4 | Destination register index |
| tag_i | input | 2 | Request tag |
| data_i | input | 32 | Data word for store |
| resp_o | output | 2 | 00 none, 01 success, 10 overflow/underflow |
| tag_o | output | 2 | Tag of the request being answered |
| data_o | output | 32 | Fetched register value, zero otherwise |

## Verification
Some properties are checked on every cycle:
- a cycle without a defined opcode yields a silent response in the next cycle;
- tags are echoed;
- arithmetic errors produce code 10;
- non-fetch commands return zero data;
- a bank register changes only when it is the write target of a write-enabled command.

Only the bench's scenarios, compared against an independent model of the bank, can show the rest:
- the arithmetic values, including the carry and borrow boundaries;
- shift amounts that take only the low five bits;
- that no write happens after an error or an undefined opcode;
- the one-cycle visibility of a write to the next request.

// File: rtl/rbx_pkg.sv
package rbx_pkg;
  localparam int DATA_W = 32;
  localparam int NREG   = 16;
  localparam int IDX_W  = $clog2(NREG);
  localparam int TAG_W  = 2;

  localparam logic [3:0] OP_ADD   = 4'b0001;
  localparam logic [3:0] OP_SUB   = 4'b0010;
  localparam logic [3:0] OP_SHL   = 4'b0101;
  localparam logic [3:0] OP_SHR   = 4'b0110;
  localparam logic [3:0] OP_STORE = 4'b1001;
  localparam logic [3:0] OP_FETCH = 4'b1010;

  typedef enum logic [1:0] {
    RESP_NONE = 2'b00,
    RESP_OK   = 2'b01,
    RESP_ERR  = 2'b10
  } resp_e;

  typedef enum logic [2:0] {
    K_ADD, K_SUB, K_SHL, K_SHR, K_STORE, K_FETCH
  } kind_e;

  typedef struct packed {
    logic  valid;
    kind_e kind;
  } dec_t;
endpackage

// File: rtl/rbx_decode.sv
module rbx_decode
  import rbx_pkg::*;
(
  input  logic [3:0] op_i,
  output dec_t       dec_o
);
  always_comb begin
    dec_o.valid = 1'b1;
    dec_o.kind  = K_ADD;
    unique case (op_i)
      OP_ADD:   dec_o.kind = K_ADD;
      OP_SUB:   dec_o.kind = K_SUB;
      OP_SHL:   dec_o.kind = K_SHL;
      OP_SHR:   dec_o.kind = K_SHR;
      OP_STORE: dec_o.kind = K_STORE;
      OP_FETCH: dec_o.kind = K_FETCH;
      default:  dec_o.valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/rbx_reg_bank.sv
module rbx_reg_bank #(
  parameter int NREG   = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  ra_i,
  input  logic [IDX_W-1:0]  rb_i,
  output logic [DATA_W-1:0] qa_o,
  output logic [DATA_W-1:0] qb_o,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wa_i,
  input  logic [DATA_W-1:0] wd_i
);
  logic [DATA_W-1:0] q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic hit;
    assign hit = we_i && (wa_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q[i] <= '0;
      else if (hit) q[i] <= wd_i;
    end

    assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && wa_i == IDX_W'(i)) |=> $stable(q[i]));
  end

  assign qa_o = q[ra_i];
  assign qb_o = q[rb_i];
endmodule

// File: rtl/rbx_shifter.sv
module rbx_shifter #(
  parameter int DATA_W = 32,
  parameter bit LEFT   = 1'b1,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [SH_W-1:0]   amt_i,
  output logic [DATA_W-1:0] y_o
);
  logic [DATA_W-1:0] st [SH_W+1];
  assign st[0] = a_i;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    if (LEFT) begin : g_l
      assign st[s+1] = amt_i[s] ? (st[s] << (1 << s)) : st[s];
    end else begin : g_r
      assign st[s+1] = amt_i[s] ? (st[s] >> (1 << s)) : st[s];
    end
  end

  assign y_o = st[SH_W];
endmodule

// File: rtl/rbx_exec.sv
module rbx_exec
  import rbx_pkg::*;
#(
  parameter int DW = 32,
  localparam int SH_W = $clog2(DW)
) (
  input  dec_t          dec_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] wd_o,
  output logic          we_o,
  output logic          err_o,
  output logic [DW-1:0] rdata_o
);
  logic [DW:0]   sum, dif;
  logic [DW-1:0] shl, shr;

  assign sum = {1'b0, a_i} + {1'b0, b_i};
  assign dif = {1'b0, a_i} - {1'b0, b_i};

  rbx_shifter #(.DATA_W(DW), .LEFT(1'b1)) u_shl (
    .a_i(a_i), .amt_i(b_i[SH_W-1:0]), .y_o(shl));
  rbx_shifter #(.DATA_W(DW), .LEFT(1'b0)) u_shr (
    .a_i(a_i), .amt_i(b_i[SH_W-1:0]), .y_o(shr));

  always_comb begin
    wd_o    = '0;
    we_o    = 1'b0;
    err_o   = 1'b0;
    rdata_o = '0;
    if (dec_i.valid) begin
      unique case (dec_i.kind)
        K_ADD:   begin err_o = sum[DW]; wd_o = sum[DW-1:0]; we_o = !sum[DW]; end
        K_SUB:   begin err_o = dif[DW]; wd_o = dif[DW-1:0]; we_o = !dif[DW]; end
        K_SHL:   begin wd_o = shl; we_o = 1'b1; end
        K_SHR:   begin wd_o = shr; we_o = 1'b1; end
        K_STORE: begin wd_o = din_i; we_o = 1'b1; end
        K_FETCH: rdata_o = a_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rbx_exec_top.sv
module rbx_exec_top
  import rbx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [3:0]  cmd_i,
  input  logic [3:0]  d1_i,
  input  logic [3:0]  d2_i,
  input  logic [3:0]  r1_i,
  input  logic [1:0]  tag_i,
  input  logic [31:0] data_i,
  output logic [1:0]  resp_o,
  output logic [1:0]  tag_o,
  output logic [31:0] data_o
);
  dec_t              dec;
  logic [DATA_W-1:0] qa, qb, wd, rdata;
  logic              we, err;

  rbx_decode u_dec (.op_i(cmd_i), .dec_o(dec));

  rbx_reg_bank #(.NREG(NREG), .DATA_W(DATA_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ra_i(d1_i[IDX_W-1:0]), .rb_i(d2_i[IDX_W-1:0]),
    .qa_o(qa), .qb_o(qb),
    .we_i(we), .wa_i(r1_i[IDX_W-1:0]), .wd_i(wd));

  rbx_exec #(.DW(DATA_W)) u_exec (
    .dec_i(dec), .a_i(qa), .b_i(qb), .din_i(data_i),
    .wd_o(wd), .we_o(we), .err_o(err), .rdata_o(rdata));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_o <= RESP_NONE;
      tag_o  <= '0;
      data_o <= '0;
    end else if (dec.valid) begin
      resp_o <= err ? RESP_ERR : RESP_OK;
      tag_o  <= tag_i;
      data_o <= rdata;
    end else begin
      resp_o <= RESP_NONE;
      tag_o  <= '0;
      data_o <= '0;
    end
  end

  assert_idle_resp_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec.valid |=> (resp_o == RESP_NONE && tag_o == '0 && data_o == '0));

  assert_tag_echo_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec.valid |=> (tag_o == $past(tag_i) && resp_o != RESP_NONE));

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec.valid && err) |=> resp_o == RESP_ERR);

  assert_err_no_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec.valid && err) |-> !we);

  assert_data_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec.valid && dec.kind != K_FETCH) |=> data_o == '0);
endmodule

// File: tb/rbx_exec_top_test.sv
module rbx_exec_top_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  cmd_i = '0, d1_i = '0, d2_i = '0, r1_i = '0;
  logic [1:0]  tag_i = '0;
  logic [31:0] data_i = '0;
  logic [1:0]  resp_o, tag_o;
  logic [31:0] data_o;

  always #2 clk = ~clk;

  rbx_exec_top uut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_i(cmd_i), .d1_i(d1_i), .d2_i(d2_i),
    .r1_i(r1_i), .tag_i(tag_i), .data_i(data_i),
    .resp_o(resp_o), .tag_o(tag_o), .data_o(data_o));

  typedef struct {
    logic [1:0]  resp;
    logic [1:0]  tag;
    logic [31:0] data;
    string       req;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] model [16];
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  task automatic send(input logic [3:0] op, input logic [3:0] a, input logic [3:0] b,
                      input logic [3:0] r, input logic [1:0] t, input logic [31:0] d,
                      input string req);
    exp_t        e;
    logic [32:0] w;
    @(negedge clk);
    cmd_i = op; d1_i = a; d2_i = b; r1_i = r; tag_i = t; data_i = d;
    e.resp = 2'b01; e.tag = t; e.data = '0; e.req = req;
    case (op)
      4'b0001: begin w = {1'b0, model[a]} + {1'b0, model[b]};
                 if (w[32]) e.resp = 2'b10; else model[r] = w[31:0]; end
      4'b0010: begin if (model[a] < model[b]) e.resp = 2'b10;
                 else model[r] = model[a] - model[b]; end
      4'b0101: model[r] = model[a] << model[b][4:0];
      4'b0110: model[r] = model[a] >> model[b][4:0];
      4'b1001: model[r] = d;
      4'b1010: e.data = model[a];
      default: begin e.resp = 2'b00; e.tag = 2'b00; end
    endcase
    sb.push_back(e);
  endtask

  task automatic idle();
    send(4'b0000, 4'd0, 4'd0, 4'd0, 2'd0, 32'd0, "R9");
  endtask

  task automatic store(input logic [3:0] r, input logic [31:0] d);
    send(4'b1001, 4'd0, 4'd0, r, r[1:0], d, "R7");
  endtask

  task automatic fetch(input logic [3:0] a, input string req);
    send(4'b1010, a, 4'd0, 4'd0, a[1:0], 32'd0, req);
  endtask

  // monitor: outputs settle after posedge; compare one cycle after issue
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_ni && sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (resp_o !== e.resp || tag_o !== e.tag || data_o !== e.data) begin
          errors++;
          $display("FAIL %s: resp=%b tag=%0d data=%h expected resp=%b tag=%0d data=%h",
                   e.req, resp_o, tag_o, data_o, e.resp, e.tag, e.data);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    #9;
    checks++;
    if (resp_o !== 2'b00 || tag_o !== 2'b00 || data_o !== 32'd0) begin
      errors++;
      $display("FAIL R1: resp=%b tag=%0d data=%h expected 00 0 0", resp_o, tag_o, data_o);
    end
    @(negedge clk);
    rst_ni = 1'b1;

    // R1: bank starts cleared
    for (int i = 0; i < 16; i++) fetch(4'(i), "R1");

    // R7 / R10: store then fetch back-to-back
    store(4'd1, 32'h0000_1234);
    fetch(4'd1, "R10");
    store(4'd2, 32'h0000_0FFF);
    store(4'd3, 32'hFFFF_FFF0);
    store(4'd4, 32'h0000_0010);
    store(4'd5, 32'h8000_0001);
    store(4'd6, 32'h0000_0023);
    store(4'd7, 32'h0000_001F);
    store(4'd8, 32'hFFFF_FFE0);

    // R2: add
    send(4'b0001, 4'd1, 4'd2, 4'd9, 2'd1, 32'hDEAD_BEEF, "R2");
    fetch(4'd9, "R2");
    send(4'b0001, 4'd3, 4'd4, 4'd10, 2'd2, 32'd0, "R2");   // exactly 2^32 -> carry
    fetch(4'd10, "R3");
    send(4'b0001, 4'd3, 4'd3, 4'd9, 2'd3, 32'd0, "R3");    // overflow, r9 kept
    fetch(4'd9, "R3");
    send(4'b0001, 4'd3, 4'd0, 4'd11, 2'd0, 32'd0, "R2");   // max-ish plus zero
    fetch(4'd11, "R2");

    // R4: subtract
    send(4'b0010, 4'd2, 4'd1, 4'd12, 2'd1, 32'd0, "R4");   // 0FFF < 1234 -> error
    fetch(4'd12, "R4");
    send(4'b0010, 4'd1, 4'd2, 4'd12, 2'd2, 32'd0, "R4");
    fetch(4'd12, "R4");
    send(4'b0010, 4'd4, 4'd4, 4'd13, 2'd3, 32'd0, "R4");   // equal -> zero
    fetch(4'd13, "R4");
    send(4'b0010, 4'd0, 4'd4, 4'd1, 2'd0, 32'd0, "R4");    // 0 - 16 underflow
    fetch(4'd1, "R4");

    // R5 / R6: shifts, amount from low five bits of d2
    send(4'b0101, 4'd5, 4'd6, 4'd14, 2'd1, 32'd0, "R5");   // amt 3
    fetch(4'd14, "R5");
    send(4'b0101, 4'd5, 4'd7, 4'd14, 2'd2, 32'd0, "R5");   // amt 31
    fetch(4'd14, "R5");
    send(4'b0101, 4'd5, 4'd8, 4'd14, 2'd3, 32'd0, "R5");   // amt 0 (upper bits set)
    fetch(4'd14, "R5");
    send(4'b0110, 4'd3, 4'd6, 4'd15, 2'd0, 32'd0, "R6");
    fetch(4'd15, "R6");
    send(4'b0110, 4'd5, 4'd7, 4'd15, 2'd1, 32'd0, "R6");
    fetch(4'd15, "R6");
    send(4'b0110, 4'd5, 4'd5, 4'd5, 2'd2, 32'd0, "R6");    // in-place, amt 1
    fetch(4'd5, "R6");

    // R9: undefined opcodes write nothing, respond nothing
    send(4'b0011, 4'd1, 4'd2, 4'd2, 2'd3, 32'hAAAA_AAAA, "R9");
    send(4'b1111, 4'd1, 4'd2, 4'd2, 2'd1, 32'h5555_5555, "R9");
    send(4'b1000, 4'd1, 4'd2, 4'd2, 2'd2, 32'h1111_1111, "R9");
    send(4'b1011, 4'd1, 4'd2, 4'd2, 2'd2, 32'h2222_2222, "R9");
    idle();
    fetch(4'd2, "R9");

    // R8: fetch data only on fetch, tags vary
    send(4'b1010, 4'd3, 4'd9, 4'd9, 2'd2, 32'hFFFF_FFFF, "R8");
    store(4'd0, 32'hCAFE_F00D);
    send(4'b1010, 4'd0, 4'd0, 4'd0, 2'd3, 32'd0, "R8");

    // R10: write then immediate use as operand
    store(4'd6, 32'h0000_0004);
    send(4'b0101, 4'd4, 4'd6, 4'd7, 2'd1, 32'd0, "R10");
    fetch(4'd7, "R10");

    for (int i = 0; i < 16; i++) fetch(4'(i), "R10");
    idle();
    idle();
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule